// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the system clock. The divide ratio comes from two small codes. A 2-bit prescaler code picks one of four odd-or-prime divides. A 4-bit scaler code picks a divide from a fixed geometric-style table. One serial clock period lasts the product of the two divides, counted in system clock cycles.

Inside each period the block raises two single-cycle strobes. The leading strobe marks the middle of the period and the trailing strobe marks its last cycle. A data shifter uses them to launch and capture bits. The clock output idles at the selected polarity. It moves to the opposite level for the second half of every period.

The codes and the polarity are sampled only when a period starts, so software may rewrite them while the clock runs. Clearing the enable ends the current period at once. Setting it again starts a fresh period from its first cycle.

Top module: `spi_baud_gen`

## Requirements
- R1: Prescaler code 0, 1, 2, 3 selects a divide of 2, 3, 5, 7 respectively.
- R2: Scaler code 0, 1, 2 selects a divide of 2, 4, 6; scaler code k for k from 3 to 15 selects a divide of 2 to the power k (8 up to 32768).
- R3: While enabled, every period is N = prescaler divide times scaler divide cycles long, and `trail_stb` is high only in the last cycle (index N-1) of each period.
- R4: `lead_stb` is high only in cycle index N/2-1 of each period, and the two strobes are never high together.
- R5: `sck` equals the period's polarity in cycle indices 0 to N/2-1 and the opposite level in indices N/2 to N-1; it flips on the clock edge that ends the leading-strobe cycle.
- R6: One clock edge after `en` is sampled low, `sck` equals the `cpol` value sampled at that edge and both strobes are low, and they stay so while `en` stays low.
- R7: On the edge that first samples `en` high, the codes and `cpol` are captured, and the following cycle is index 0 of the first period.
- R8: Codes and `cpol` are sampled only on the edge that ends a period (or the edge of R7); a change at any other time first takes effect in the next period, and a change present at the edge ending a period takes effect in the period that this edge starts.
- R9: Clearing `en` in mid-period abandons that period; when `en` is set again, the next period starts at index 0 and runs its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Runs the divider when high |
| cpol | input | 1 | Idle level of the serial clock |
| pre_sel | input | PRE_W | Prescaler code (2 bits) |
| scl_sel | input | SCL_W | Scaler code (4 bits) |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe before the leading clock edge |
| trail_stb | output | 1 | One-cycle strobe in the last cycle of a period |

## Verification
The assertions check four things on every cycle. They confirm that the two strobes are exclusive and each lasts a single cycle. They confirm that the clock flips after every leading strobe and settles to the sampled polarity after every trailing strobe. They confirm that a disabled block holds the idle level with no strobes. The exact position of each strobe inside a period, the period length for each code pair, and the deferral of code changes to the boundary depend on counting whole periods. Only the bench's sweeps over codes and polarities, together with its mid-period change and abort scenarios, can show these.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

   // divide applied by the first (prescaler) stage
   function automatic int pre_value(input int code);
      case (code)
         0:       return 2;
         1:       return 3;
         2:       return 5;
         default: return 7;
      endcase
   endfunction

   // divide applied by the second (scaler) stage
   function automatic int scl_value(input int code);
      if (code < 3) return 2 * (code + 1);
      return 1 << code;
   endfunction

   localparam int PRE_MAX = 7;

endpackage

// File: rtl/spi_baud_pre.sv
module spi_baud_pre #(
   parameter int PRE_W = 2,
   parameter int PC_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] code,
   output logic             tick
);
   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] pc_last;

   always_comb pc_last = PC_W'(spi_baud_pkg::pre_value(int'(code)) - 1);

   assign tick = run && (pc == pc_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pc <= '0;
      else if (!run || tick) pc <= '0;
      else                   pc <= pc + PC_W'(1);
   end
endmodule

// File: rtl/spi_baud_scl.sv
module spi_baud_scl #(
   parameter int SCL_W = 4,
   parameter int SC_W  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [SCL_W-1:0] code,
   output logic             lead,
   output logic             trail
);
   logic [SC_W-1:0] sc;
   logic [SC_W-1:0] sc_last;
   logic [SC_W-1:0] sc_mid;

   always_comb begin
      sc_last = SC_W'(spi_baud_pkg::scl_value(int'(code)) - 1);
      sc_mid  = SC_W'(spi_baud_pkg::scl_value(int'(code)) / 2 - 1);
   end

   assign lead  = tick && (sc == sc_mid);
   assign trail = tick && (sc == sc_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sc <= '0;
      else if (!run)  sc <= '0;
      else if (tick)  sc <= trail ? '0 : sc + SC_W'(1);
   end
endmodule

// File: rtl/spi_baud_out.sv
module spi_baud_out (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic run,
   input  logic cpol,
   input  logic cpol_q,
   input  logic lead,
   input  logic trail,
   output logic sck
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sck <= 1'b0;
      else if (!en || !run || trail) sck <= cpol;
      else if (lead)                 sck <= ~cpol_q;
   end
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int PRE_W = 2,
   parameter int SCL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cpol,
   input  logic [PRE_W-1:0] pre_sel,
   input  logic [SCL_W-1:0] scl_sel,
   output logic             sck,
   output logic             lead_stb,
   output logic             trail_stb
);
   localparam int SCL_MAX = spi_baud_pkg::scl_value(2**SCL_W - 1);
   localparam int SC_W    = $clog2(SCL_MAX);
   localparam int PC_W    = $clog2(spi_baud_pkg::PRE_MAX + 1);

   generate
      if (PRE_W != 2) begin : g_bad_pre
         $error("spi_baud_gen: PRE_W must be 2");
      end
      if (SCL_W < 2 || SCL_W > 4) begin : g_bad_scl
         $error("spi_baud_gen: SCL_W must be 2 to 4");
      end
   endgenerate

   logic             run;
   logic             cpol_q;
   logic [PRE_W-1:0] pre_q;
   logic [SCL_W-1:0] scl_q;
   logic             tick;
   logic             lead;
   logic             trail;
   logic             load;

   assign load = en && (!run || trail);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         cpol_q <= 1'b0;
         pre_q  <= '0;
         scl_q  <= '0;
      end else begin
         run <= en;
         if (load) begin
            pre_q  <= pre_sel;
            scl_q  <= scl_sel;
            cpol_q <= cpol;
         end
      end
   end

   spi_baud_pre #(.PRE_W(PRE_W), .PC_W(PC_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .code(pre_q), .tick(tick)
   );

   spi_baud_scl #(.SCL_W(SCL_W), .SC_W(SC_W)) u_scl (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .code(scl_q),
      .lead(lead), .trail(trail)
   );

   spi_baud_out u_out (
      .clk(clk), .rst_n(rst_n), .en(en), .run(run), .cpol(cpol),
      .cpol_q(cpol_q), .lead(lead), .trail(trail), .sck(sck)
   );

   assign lead_stb  = lead;
   assign trail_stb = trail;
endmodule

// File: rtl/spi_baud_chk.sv
module spi_baud_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic cpol,
   input logic sck,
   input logic lead_stb,
   input logic trail_stb
);
   // R4: strobes never coincide
   a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lead_stb, trail_stb}));

   // R3: trailing strobe lasts one cycle
   a_r3_trail_single: assert property (@(posedge clk) disable iff (!rst_n)
      trail_stb |=> !trail_stb);

   // R4: leading strobe lasts one cycle
   a_r4_lead_single: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |=> !lead_stb);

   // R5: clock flips after each leading strobe
   a_r5_lead_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_stb && en) |=> (sck != $past(sck)));

   // R8: a new period opens at the polarity sampled at the boundary
   a_r8_boundary_pol: assert property (@(posedge clk) disable iff (!rst_n)
      (trail_stb && en) |=> (sck == $past(cpol)));

   // R6: disabled block idles quietly
   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!lead_stb && !trail_stb && sck == $past(cpol)));
endmodule

bind spi_baud_gen spi_baud_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .sck(sck),
   .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/sim_spi_baud_gen.sv
module sim_spi_baud_gen;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       cpol = 1'b0;
   logic [1:0] pre_sel = '0;
   logic [3:0] scl_sel = '0;
   logic       sck, lead_stb, trail_stb;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   spi_baud_gen u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .pre_sel(pre_sel),
      .scl_sel(scl_sel), .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb)
   );

   function automatic int ref_pre(input int c);
      case (c)
         0: return 2;
         1: return 3;
         2: return 5;
         default: return 7;
      endcase
   endfunction

   function automatic int ref_scl(input int c);
      if (c < 3) return 2 * c + 2;
      return 2 ** c;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // checks one period; optionally changes codes at index chg_at or drops en at stop_at
   task automatic run_period(input int pc, input int sc, input bit pol,
                             input int chg_at, input int npc, input int nsc, input bit npol,
                             input int stop_at);
      int n;
      n = ref_pre(pc) * ref_scl(sc);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk("R3 R1 R2 trail_stb", int'(trail_stb), int'(k == n - 1));
         chk("R4 lead_stb", int'(lead_stb), int'(k == n / 2 - 1));
         chk("R5 sck", int'(sck), int'((k >= n / 2) ? !pol : pol));
         if (k == chg_at) begin
            pre_sel = 2'(npc); scl_sel = 4'(nsc); cpol = npol;
         end
         if (k == stop_at) begin
            en = 1'b0;
            @(posedge clk);
            return;
         end
         @(posedge clk);
      end
   endtask

   // idle check, then enable with given codes (R6, R7)
   task automatic start(input int pc, input int sc, input bit pol);
      @(negedge clk);
      en = 1'b0; cpol = pol;
      @(posedge clk);
      @(negedge clk);
      chk("R6 idle sck", int'(sck), int'(pol));
      chk("R6 idle lead", int'(lead_stb), 0);
      chk("R6 idle trail", int'(trail_stb), 0);
      pre_sel = 2'(pc); scl_sel = 4'(sc); en = 1'b1;
      @(posedge clk);
   endtask

   initial begin
      #(CLK_P * 180000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R6 reset sck", int'(sck), 0);
      chk("R6 reset lead", int'(lead_stb), 0);
      chk("R6 reset trail", int'(trail_stb), 0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 R5 R7: sweep prescaler codes, small scaler codes, both polarities
      for (int p = 0; p < 2; p++)
         for (int a = 0; a < 4; a++)
            for (int b = 0; b < 6; b++) begin
               start(a, b, p[0]);
               run_period(a, b, p[0], -1, 0, 0, 0, -1);
               run_period(a, b, p[0], -1, 0, 0, 0, -1);
            end

      // R2: mid and top scaler codes
      start(1, 9, 1'b1);
      run_period(1, 9, 1'b1, -1, 0, 0, 0, -1);
      start(0, 15, 1'b0);
      run_period(0, 15, 1'b0, -1, 0, 0, 0, -1);

      // R8: change mid-period takes effect only at the next period
      start(0, 0, 1'b0);
      run_period(0, 0, 1'b0, 1, 1, 1, 1'b1, -1);
      run_period(1, 1, 1'b1, -1, 0, 0, 0, -1);
      // R8: change present at the boundary edge applies to the next period
      start(2, 0, 1'b0);
      run_period(2, 0, 1'b0, 9, 0, 2, 1'b1, -1);
      run_period(0, 2, 1'b1, -1, 0, 0, 0, -1);

      // R9: abort after the leading edge, then restart a full period
      start(1, 1, 1'b0);
      run_period(1, 1, 1'b0, -1, 0, 0, 0, 7);
      @(negedge clk);
      chk("R9 abort sck", int'(sck), 0);
      chk("R9 abort lead", int'(lead_stb), 0);
      chk("R9 abort trail", int'(trail_stb), 0);
      en = 1'b1;
      @(posedge clk);
      run_period(1, 1, 1'b0, -1, 0, 0, 0, -1);
      run_period(1, 1, 1'b0, -1, 0, 0, 0, -1);

      // R6: polarity follows cpol while idle
      @(negedge clk);
      en = 1'b0; cpol = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R6 idle follows cpol", int'(sck), 1);
      cpol = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R6 idle follows cpol", int'(sck), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule